// File: doc/BRIEF.md
# Bank Return Stack Controller

This block holds the 4-bit bank number that sits above a 16-bit CPU address, which gives a 20-bit physical address space made of sixteen 64 KB banks. Next to the CPU's own return-address stack it keeps a private last-in, first-out store of bank numbers. When the CPU returns through its own stack, it therefore lands back in the bank it came from as well as at the right 16-bit offset.

The block does no instruction decoding. Each control event reaches it as a single-cycle strobe from the surrounding sequencer: call to a target bank, plain jump to a bank, subroutine return, IRQ entry, NMI entry and interrupt return. IRQ and NMI each have a writable handler-bank register, so the two handlers can live in different banks. Entering either interrupt saves the running bank before switching. The physical address is formed combinationally from the registered current bank and the live CPU address.

Top module: `bank_stack_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the current bank is 0, both sticky flags are 0, the IRQ and NMI handler-bank registers hold 0 and the bank store is empty.
- R2: `phys_addr_o` equals `{cur_bank_o, cpu_addr_i}` at all times, with bank bits 19:16 and CPU bits 15:0, and it follows `cpu_addr_i` with no clock delay.
- R3: A call strobe pushes the current bank onto the store, and from the next cycle `cur_bank_o` equals `call_bank_i`.
- R4: A return strobe pops the store, and from the next cycle `cur_bank_o` equals the popped value, so nested calls unwind in reverse order.
- R5: A jump strobe loads `jmp_bank_i` into the current bank and leaves the store untouched.
- R6: An IRQ strobe pushes the current bank and then loads the IRQ handler-bank register into the current bank.
- R7: An NMI strobe pushes the current bank and then loads the NMI handler-bank register, which is separate from the IRQ one.
- R8: An interrupt-return strobe pops the store exactly as a return does.
- R9: A push while the store already holds `DEPTH` entries drops the entry and sets the sticky `overflow_o` flag. The bank switch of that event still takes place.
- R10: A pop while the store is empty sets the sticky `underflow_o` flag and leaves the current bank unchanged. Both flags clear only on reset.
- R11: When several strobes arrive in one cycle, only one event acts. NMI comes first, then IRQ, then return or interrupt return, then call, then jump.
- R12: Writes to the handler-bank registers (`irq_bank_we_i`, `nmi_bank_we_i` with `bank_wdata_i`) take effect from the next cycle. An interrupt in the same cycle as a write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Subroutine call strobe |
| call_bank_i | input | 4 | Target bank of the call |
| ret_i | input | 1 | Subroutine return strobe |
| jmp_i | input | 1 | Plain jump strobe |
| jmp_bank_i | input | 4 | Target bank of the jump |
| irq_i | input | 1 | IRQ entry strobe |
| nmi_i | input | 1 | NMI entry strobe |
| rti_i | input | 1 | Interrupt return strobe |
| irq_bank_we_i | input | 1 | Write enable of the IRQ handler-bank register |
| nmi_bank_we_i | input | 1 | Write enable of the NMI handler-bank register |
| bank_wdata_i | input | 4 | Data for the handler-bank registers |
| cpu_addr_i | input | 16 | CPU logical address |
| cur_bank_o | output | 4 | Current bank |
| phys_addr_o | output | 20 | Composed 20-bit address |
| overflow_o | output | 1 | Sticky store-overflow flag |
| underflow_o | output | 1 | Sticky store-underflow flag |

## Verification
On every cycle the bound checker checks several things. Both flags must stay sticky, and an underflow must leave the bank unchanged. The bank loaded after each winning event must match the event's own source: call target, jump target, IRQ register or NMI register. Unwinding order, which values come back after overflow, and the full priority among coincident strobes depend on history. A small-depth bench shows these by driving every strobe combination against an arithmetic model and by running sweeps of nested calls and returns over all sixteen banks.

// File: rtl/bank_stack_pkg.sv
package bank_stack_pkg;
  localparam int BANK_W = 4;

  typedef logic [BANK_W-1:0] bank_t;

  // Source of the next current-bank value
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_CALL,
    SRC_JMP,
    SRC_IRQ,
    SRC_NMI,
    SRC_POP
  } bank_src_e;

  typedef struct packed {
    logic      push;
    logic      pop;
    bank_src_e src;
  } bank_op_t;
endpackage

// File: rtl/bank_event_arb.sv
module bank_event_arb
  import bank_stack_pkg::*;
(
  input  logic     call_i,
  input  logic     ret_i,
  input  logic     jmp_i,
  input  logic     irq_i,
  input  logic     nmi_i,
  input  logic     rti_i,
  output bank_op_t op_o
);
  // Fixed priority: NMI > IRQ > return/interrupt return > call > jump
  always_comb begin
    op_o.push = 1'b0;
    op_o.pop  = 1'b0;
    op_o.src  = SRC_HOLD;
    if (nmi_i) begin
      op_o.push = 1'b1;
      op_o.src  = SRC_NMI;
    end else if (irq_i) begin
      op_o.push = 1'b1;
      op_o.src  = SRC_IRQ;
    end else if (ret_i || rti_i) begin
      op_o.pop  = 1'b1;
      op_o.src  = SRC_POP;
    end else if (call_i) begin
      op_o.push = 1'b1;
      op_o.src  = SRC_CALL;
    end else if (jmp_i) begin
      op_o.src  = SRC_JMP;
    end
  end
endmodule

// File: rtl/bank_lifo.sv
module bank_lifo
  import bank_stack_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  logic  pop_i,
  input  bank_t push_data_i,
  output bank_t top_o,
  output logic  pop_ok_o,
  output logic  overflow_o,
  output logic  underflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, udf_q, udf_d;
  logic             full, empty, do_push, do_pop;
  logic [PTR_W-1:0] top_idx;
  bank_t            mem [DEPTH];

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push_i && !full;
    do_pop  = pop_i && !empty;
    top_idx = empty ? '0 : PTR_W'(cnt_q - CNT_W'(1));
    cnt_d   = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
    ovf_d   = ovf_q || (push_i && full);
    udf_d   = udf_q || (pop_i && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  // One register per entry, written only when it is the slot being filled
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_push && (cnt_q == CNT_W'(gi))) mem[gi] <= push_data_i;
    end
  end

  assign top_o       = mem[top_idx];
  assign pop_ok_o    = do_pop;
  assign overflow_o  = ovf_q;
  assign underflow_o = udf_q;
endmodule

// File: rtl/bank_stack_ctrl.sv
module bank_stack_ctrl
  import bank_stack_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CPU_AW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     call_i,
  input  logic [BANK_W-1:0]        call_bank_i,
  input  logic                     ret_i,
  input  logic                     jmp_i,
  input  logic [BANK_W-1:0]        jmp_bank_i,
  input  logic                     irq_i,
  input  logic                     nmi_i,
  input  logic                     rti_i,
  input  logic                     irq_bank_we_i,
  input  logic                     nmi_bank_we_i,
  input  logic [BANK_W-1:0]        bank_wdata_i,
  input  logic [CPU_AW-1:0]        cpu_addr_i,
  output logic [BANK_W-1:0]        cur_bank_o,
  output logic [BANK_W+CPU_AW-1:0] phys_addr_o,
  output logic                     overflow_o,
  output logic                     underflow_o
);
  bank_op_t op;
  bank_t    cur_bank_q, cur_bank_d;
  bank_t    irq_bank_q, nmi_bank_q;
  bank_t    stk_top;
  logic     pop_ok, cur_en;

  bank_event_arb u_arb (
    .call_i (call_i),
    .ret_i  (ret_i),
    .jmp_i  (jmp_i),
    .irq_i  (irq_i),
    .nmi_i  (nmi_i),
    .rti_i  (rti_i),
    .op_o   (op)
  );

  bank_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (op.push),
    .pop_i       (op.pop),
    .push_data_i (cur_bank_q),
    .top_o       (stk_top),
    .pop_ok_o    (pop_ok),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  always_comb begin
    cur_bank_d = cur_bank_q;
    unique case (op.src)
      SRC_CALL: cur_bank_d = call_bank_i;
      SRC_JMP:  cur_bank_d = jmp_bank_i;
      SRC_IRQ:  cur_bank_d = irq_bank_q;
      SRC_NMI:  cur_bank_d = nmi_bank_q;
      SRC_POP:  cur_bank_d = pop_ok ? stk_top : cur_bank_q;
      default:  cur_bank_d = cur_bank_q;
    endcase
    cur_en = (op.src != SRC_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_bank_q <= '0;
    else if (cur_en) cur_bank_q <= cur_bank_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             irq_bank_q <= '0;
    else if (irq_bank_we_i) irq_bank_q <= bank_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             nmi_bank_q <= '0;
    else if (nmi_bank_we_i) nmi_bank_q <= bank_wdata_i;
  end

  assign cur_bank_o  = cur_bank_q;
  assign phys_addr_o = {cur_bank_q, cpu_addr_i};
endmodule

// File: rtl/bank_stack_chk.sv
module bank_stack_chk #(
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic [BW-1:0] call_bank_i,
  input logic          ret_i,
  input logic          jmp_i,
  input logic [BW-1:0] jmp_bank_i,
  input logic          irq_i,
  input logic          nmi_i,
  input logic          rti_i,
  input logic [BW-1:0] irq_bank_q,
  input logic [BW-1:0] nmi_bank_q,
  input logic [BW-1:0] cur_bank_o,
  input logic          overflow_o,
  input logic          underflow_o
);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  assert_udf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

  assert_udf_keeps_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow_o) |-> $stable(cur_bank_o));

  assert_nmi_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |=> cur_bank_o == $past(nmi_bank_q));

  assert_irq_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !nmi_i) |=> cur_bank_o == $past(irq_bank_q));

  assert_call_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !nmi_i && !irq_i && !ret_i && !rti_i) |=> cur_bank_o == $past(call_bank_i));

  assert_jmp_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_i && !call_i && !nmi_i && !irq_i && !ret_i && !rti_i)
      |=> cur_bank_o == $past(jmp_bank_i));
endmodule

bind bank_stack_ctrl bank_stack_chk #(.BW(bank_stack_pkg::BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .call_i      (call_i),
  .call_bank_i (call_bank_i),
  .ret_i       (ret_i),
  .jmp_i       (jmp_i),
  .jmp_bank_i  (jmp_bank_i),
  .irq_i       (irq_i),
  .nmi_i       (nmi_i),
  .rti_i       (rti_i),
  .irq_bank_q  (irq_bank_q),
  .nmi_bank_q  (nmi_bank_q),
  .cur_bank_o  (cur_bank_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/tb_bank_stack_ctrl.sv
module tb_bank_stack_ctrl;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 0, ret_i = 0, jmp_i = 0, irq_i = 0, nmi_i = 0, rti_i = 0;
  logic        irq_bank_we_i = 0, nmi_bank_we_i = 0;
  logic [3:0]  call_bank_i = 0, jmp_bank_i = 0, bank_wdata_i = 0;
  logic [15:0] cpu_addr_i = 0;
  logic [3:0]  cur_bank_o;
  logic [19:0] phys_addr_o;
  logic        overflow_o, underflow_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int m_stk[D];
  int m_cnt, m_cur, m_irq, m_nmi;
  bit m_ovf, m_udf;

  always #2 clk = ~clk;

  bank_stack_ctrl #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n),
    .call_i(call_i), .call_bank_i(call_bank_i), .ret_i(ret_i),
    .jmp_i(jmp_i), .jmp_bank_i(jmp_bank_i), .irq_i(irq_i), .nmi_i(nmi_i),
    .rti_i(rti_i), .irq_bank_we_i(irq_bank_we_i), .nmi_bank_we_i(nmi_bank_we_i),
    .bank_wdata_i(bank_wdata_i), .cpu_addr_i(cpu_addr_i),
    .cur_bank_o(cur_bank_o), .phys_addr_o(phys_addr_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(cur_bank_o, m_cur, {tag, " bank"});
    chk(overflow_o, m_ovf, {tag, " overflow"});
    chk(underflow_o, m_udf, {tag, " underflow"});
    chk(phys_addr_o, (m_cur << 16) | cpu_addr_i, {tag, " R2 addr"});
  endtask

  task automatic m_push();
    if (m_cnt == D) m_ovf = 1;
    else begin m_stk[m_cnt] = m_cur; m_cnt++; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_cnt = 0; m_cur = 0; m_irq = 0; m_nmi = 0; m_ovf = 0; m_udf = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // One cycle of stimulus, model update, then check at the next falling edge
  task automatic ev(input bit c, input int cb, input bit r, input bit i,
                    input bit n, input bit t, input bit j, input int jb,
                    input bit iw, input bit nw, input int wd, input string tag);
    @(negedge clk);
    call_i = c; call_bank_i = 4'(cb); ret_i = r; irq_i = i; nmi_i = n;
    rti_i = t; jmp_i = j; jmp_bank_i = 4'(jb);
    irq_bank_we_i = iw; nmi_bank_we_i = nw; bank_wdata_i = 4'(wd);
    cpu_addr_i = cpu_addr_i + 16'h1357;
    @(negedge clk);
    call_i = 0; ret_i = 0; irq_i = 0; nmi_i = 0; rti_i = 0; jmp_i = 0;
    irq_bank_we_i = 0; nmi_bank_we_i = 0;
    if (n) begin m_push(); m_cur = m_nmi; end
    else if (i) begin m_push(); m_cur = m_irq; end
    else if (r || t) begin
      if (m_cnt == 0) m_udf = 1;
      else begin m_cnt--; m_cur = m_stk[m_cnt]; end
    end
    else if (c) begin m_push(); m_cur = cb; end
    else if (j) m_cur = jb;
    if (iw) m_irq = wd;
    if (nw) m_nmi = wd;
    check_all(tag);
  endtask

  task automatic call_to(input int b, input string tag);  ev(1,b,0,0,0,0,0,0,0,0,0,tag); endtask
  task automatic ret_once(input string tag);              ev(0,0,1,0,0,0,0,0,0,0,0,tag); endtask
  task automatic rti_once(input string tag);              ev(0,0,0,0,0,1,0,0,0,0,0,tag); endtask
  task automatic jmp_to(input int b, input string tag);   ev(0,0,0,0,0,0,1,b,0,0,0,tag); endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_cur = 0; m_irq = 0; m_nmi = 0; m_ovf = 0; m_udf = 0;
    // R1: state during and just after reset
    repeat (2) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");
    ret_once("R1 empty store pop");   // store empty after reset -> underflow
    do_reset();
    ev(0,0,0,1,0,0,0,0,0,0,0,"R1 irq reg reset value");
    ev(0,0,0,0,1,0,0,0,0,0,0,"R1 nmi reg reset value");
    do_reset();

    // R2: combinational address composition across banks and addresses
    for (int b = 0; b < 16; b++) begin
      jmp_to(b, "R2 bank set");
      for (int a = 0; a < 4; a++) begin
        cpu_addr_i = 16'(a * 16'h4111 + b);
        #0.5;
        chk(phys_addr_o, (b << 16) | cpu_addr_i, "R2 composed address");
      end
    end
    do_reset();

    // R3/R4: every call target, followed by a return
    for (int b = 0; b < 16; b++) begin
      call_to(b, "R3 call target");
      ret_once("R4 return restores");
    end
    // R3/R4: nested to full depth, unwound in reverse order
    for (int s = 0; s < 16; s += 4) begin
      for (int k = 0; k < D; k++) call_to((s + k * 5) % 16, "R3 nested call");
      for (int k = 0; k < D; k++) ret_once("R4 nested return");
    end

    // R5: jumps leave the store alone
    call_to(5, "R5 setup call");
    for (int b = 0; b < 16; b++) jmp_to(15 - b, "R5 jump");
    ret_once("R5 return after jumps");

    // R6/R7/R8/R12: handler banks
    ev(0,0,0,0,0,0,0,0,1,0,10,"R12 irq reg write");
    ev(0,0,0,0,0,0,0,0,0,1,12,"R12 nmi reg write");
    jmp_to(3, "R6 setup");
    ev(0,0,0,1,0,0,0,0,0,0,0,"R6 irq entry");
    rti_once("R8 irq return");
    ev(0,0,0,0,1,0,0,0,0,0,0,"R7 nmi entry");
    ev(0,0,0,1,0,0,0,0,0,0,0,"R6 irq inside nmi");
    rti_once("R8 return to nmi");
    rti_once("R8 return to origin");
    ev(0,0,0,0,1,0,0,0,0,1,7,"R12 nmi with same-cycle write");
    rti_once("R8 back");
    ev(0,0,0,0,1,0,0,0,0,0,0,"R12 nmi uses new value");
    rti_once("R8 back again");

    // R9/R10: overflow drops the entry, underflow keeps the bank
    do_reset();
    for (int k = 0; k < D + 1; k++) call_to(k + 1, "R9 push toward overflow");
    call_to(9, "R9 overflow sticky");
    for (int k = 0; k < D; k++) ret_once("R9 stored entries return");
    ret_once("R10 pop when empty");
    jmp_to(6, "R10 sticky after jump");
    ret_once("R10 bank kept on underflow");

    // R11: every combination of the six strobes against the model
    do_reset();
    ev(0,0,0,0,0,0,0,0,1,0,6,"R11 setup irq reg");
    ev(0,0,0,0,0,0,0,0,0,1,9,"R11 setup nmi reg");
    for (int m = 0; m < 64; m++) begin
      ev(m[0], m % 16, m[1], m[2], m[3], m[4], m[5], (m * 7) % 16,
         0, 0, 0, "R11 priority sweep");
      if (m % 8 == 7) do_reset();
      if (m % 8 == 7) begin
        ev(0,0,0,0,0,0,0,0,1,0,6,"R11 re-setup irq reg");
        ev(0,0,0,0,0,0,0,0,0,1,9,"R11 re-setup nmi reg");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule